// File: doc/BRIEF.md
# Debug trigger match unit

This unit holds a small bank of programmable debug triggers and checks each processor access against all of them at once. An access is described by its kind (instruction fetch, load or store), its address, its data, the privilege level it runs at, whether the hart is already halted for debug, and whether the hart currently runs with 32-bit words. Each trigger has a control word and a compare value. The control word holds enables for each access kind and each privilege level, an operand select, a match mode, a chain bit and an action code. Both registers are loaded through a single write port.

The result is produced in the same cycle as the access, with no register in between. A hit flag, the index of the firing trigger and that trigger's action code are sent to the surrounding debug logic. That logic decides whether to raise an exception, halt, or drive a trace event. Triggers can be chained, so that a group fires only when every member matches the same access. This allows, for example, an address and a data condition to be required together.

Top module: `dbg_trig_match`

## Requirements
- R1: Reset clears every control word and compare value. Until a trigger is configured, no access produces a hit.
- R2: A trigger is a candidate only if two enables are set: its enable for the access kind, and its enable for the privilege level. Kind codes are 0 for fetch, 1 for load and 2 for store, and code 3 matches nothing. Privilege codes are 0 for U, 1 for S and 3 for M, and code 2 matches nothing.
- R3: While `halted` is high, or while `acc_valid` is low, `hit` stays low.
- R4: When the control bit `use_data` (bit 6) is set, the compared value is `acc_data`. Otherwise it is `acc_addr`.
- R5: Mode 0 (equal) matches when the value equals the compare value.
- R6: Mode 1 (range) first counts the run of ones at the bottom of the compare value. That many low bits are cleared in both operands, and the remaining bits must be equal.
- R7: Mode 2 matches when the value is greater than or equal to the compare value. Mode 3 matches when the value is strictly less. Both comparisons are unsigned. Modes 6 and 7 never match.
- R8: Modes 4 and 5 use a mask taken from the upper half of the compare value, shifted down. In mode 4, the value ANDed with the mask must equal the compare value ANDed with the mask. In mode 5, the value's upper half is shifted down and masked, and must equal the compare value ANDed with the mask.
- R9: When `narrow` is high, only bits 31:0 of the value and of the compare value take part. In that case the half width used by modes 4 and 5 is 16.
- R10: A trigger with its chain bit (bit 10) set never fires on its own. A chain is a run of chained triggers closed by the next unchained one. It fires at the closing trigger, and only if every member matches. If the last trigger is chained, that chain never fires.
- R11: When several triggers fire, `hit_idx` gives the lowest firing index and `hit_action` gives that trigger's action field. Both appear in the same cycle as the access.
- R12: A write with `cfg_cmp` low loads `cfg_wdata[13:0]` into the control word of trigger `cfg_idx`. The bits are: 0 fetch, 1 load, 2 store, 3 U, 4 S, 5 M, 6 use_data, 9:7 mode, 10 chain, 13:11 action. A write with `cfg_cmp` high loads the compare value. The new contents take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the trigger bank |
| cfg_cmp | input | 1 | 1 selects the compare value, 0 the control word |
| cfg_idx | input | IDX_W | Trigger being written |
| cfg_wdata | input | XLEN | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | Access kind code |
| acc_addr | input | XLEN | Access address |
| acc_data | input | XLEN | Access data |
| acc_priv | input | 2 | Privilege level code |
| halted | input | 1 | Hart already halted for debug |
| narrow | input | 1 | 32-bit word mode |
| hit | output | 1 | A trigger fired |
| hit_idx | output | IDX_W | Lowest firing trigger |
| hit_action | output | 3 | Action field of that trigger |

## Verification
All state in this block lives in the trigger bank, so a stored control or compare bit that is wrong appears at the ports only when an access exercises that bit. Once that happens, the effect shows in the same cycle: a missing hit, a spurious hit, or a wrong index or action. For this reason the stimulus rewrites the bank and then, on the next cycle, issues accesses that sit just inside and just outside each mode's boundary. A chain defect can hide while the opposite member also fails, so the chain cases try each member's failure on its own and also check which index takes precedence.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
   // access kinds
   localparam logic [1:0] KIND_FETCH = 2'd0;
   localparam logic [1:0] KIND_LOAD  = 2'd1;
   localparam logic [1:0] KIND_STORE = 2'd2;
   // privilege levels
   localparam logic [1:0] LVL_U = 2'd0;
   localparam logic [1:0] LVL_S = 2'd1;
   localparam logic [1:0] LVL_M = 2'd3;
   // compare modes
   localparam logic [2:0] CMP_EQ     = 3'd0;
   localparam logic [2:0] CMP_RANGE  = 3'd1;
   localparam logic [2:0] CMP_GE     = 3'd2;
   localparam logic [2:0] CMP_LT     = 3'd3;
   localparam logic [2:0] CMP_LOMASK = 3'd4;
   localparam logic [2:0] CMP_HIMASK = 3'd5;

   typedef struct packed {
      logic [2:0] action;
      logic       chain;
      logic [2:0] mode;
      logic       use_data;
      logic       en_m;
      logic       en_s;
      logic       en_u;
      logic       en_store;
      logic       en_load;
      logic       en_fetch;
   } trig_ctl_t;

   localparam int CTL_W = $bits(trig_ctl_t);
endpackage

// File: rtl/dtm_trig_bank.sv
module dtm_trig_bank
   import dtm_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 64,
   localparam int IDX_W   = $clog2(NUM_TRIG)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           wr_cmp,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [XLEN-1:0]                wr_data,
   output trig_ctl_t [NUM_TRIG-1:0]       ctl_q,
   output logic [NUM_TRIG-1:0][XLEN-1:0]  cmp_q
);
   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctl_q[g] <= '0;
            cmp_q[g] <= '0;
         end else if (sel) begin
            if (wr_cmp) cmp_q[g] <= wr_data;
            else        ctl_q[g] <= trig_ctl_t'(wr_data[CTL_W-1:0]);
         end
      end
   end
endmodule

// File: rtl/dtm_cmp.sv
module dtm_cmp
   import dtm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  trig_ctl_t         ctl,
   input  logic [XLEN-1:0]   cmp_val,
   input  logic [1:0]        kind,
   input  logic [1:0]        priv,
   input  logic [XLEN-1:0]   addr,
   input  logic [XLEN-1:0]   data,
   input  logic              narrow,
   output logic              match
);
   localparam int HALF  = XLEN / 2;
   localparam int NHALF = (XLEN > 32) ? 16 : HALF;

   logic            narrow_eff;
   logic [XLEN-1:0] wmask;

   if (XLEN > 32) begin : g_wide
      assign narrow_eff = narrow;
      assign wmask = narrow ? {{(XLEN-32){1'b0}}, {32{1'b1}}} : {XLEN{1'b1}};
   end else begin : g_native
      assign narrow_eff = 1'b0;
      assign wmask = {XLEN{1'b1}};
      logic unused_narrow;
      assign unused_narrow = narrow;
   end

   logic [XLEN-1:0] val, cv, tail_ones, keep, hmask, vhigh;
   logic            kind_ok, priv_ok, val_ok;

   assign val       = (ctl.use_data ? data : addr) & wmask;
   assign cv        = cmp_val & wmask;
   assign tail_ones = cv & ~(cv + {{(XLEN-1){1'b0}}, 1'b1});
   assign keep      = ~tail_ones;
   assign hmask     = narrow_eff ? (cv >> NHALF) : (cv >> HALF);
   assign vhigh     = narrow_eff ? (val >> NHALF) : (val >> HALF);

   always_comb begin
      unique case (kind)
         KIND_FETCH: kind_ok = ctl.en_fetch;
         KIND_LOAD:  kind_ok = ctl.en_load;
         KIND_STORE: kind_ok = ctl.en_store;
         default:    kind_ok = 1'b0;
      endcase
      unique case (priv)
         LVL_U:   priv_ok = ctl.en_u;
         LVL_S:   priv_ok = ctl.en_s;
         LVL_M:   priv_ok = ctl.en_m;
         default: priv_ok = 1'b0;
      endcase
      unique case (ctl.mode)
         CMP_EQ:     val_ok = (val == cv);
         CMP_RANGE:  val_ok = ((val & keep) == (cv & keep));
         CMP_GE:     val_ok = (val >= cv);
         CMP_LT:     val_ok = (val < cv);
         CMP_LOMASK: val_ok = ((val & hmask) == (cv & hmask));
         CMP_HIMASK: val_ok = ((vhigh & hmask) == (cv & hmask));
         default:    val_ok = 1'b0;
      endcase
   end

   assign match = kind_ok && priv_ok && val_ok;
endmodule

// File: rtl/dtm_resolve.sv
module dtm_resolve #(
   parameter int NUM_TRIG = 4,
   localparam int IDX_W   = $clog2(NUM_TRIG)
) (
   input  logic [NUM_TRIG-1:0]       match,
   input  logic [NUM_TRIG-1:0]       chain,
   input  logic [NUM_TRIG-1:0][2:0]  action,
   output logic                      hit,
   output logic [IDX_W-1:0]          hit_idx,
   output logic [2:0]                hit_action
);
   logic [NUM_TRIG:0]   ok_v;
   logic [NUM_TRIG-1:0] fire;

   assign ok_v[0] = 1'b1;
   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_link
      assign fire[g]   = !chain[g] && ok_v[g] && match[g];
      assign ok_v[g+1] = chain[g] ? (ok_v[g] && match[g]) : 1'b1;
   end

   logic unused_tail;
   assign unused_tail = ok_v[NUM_TRIG];

   always_comb begin
      hit        = 1'b0;
      hit_idx    = '0;
      hit_action = '0;
      for (int i = NUM_TRIG - 1; i >= 0; i--) begin
         if (fire[i]) begin
            hit        = 1'b1;
            hit_idx    = IDX_W'(i);
            hit_action = action[i];
         end
      end
   end
endmodule

// File: rtl/dbg_trig_match.sv
module dbg_trig_match
   import dtm_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 64,
   localparam int IDX_W   = $clog2(NUM_TRIG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_cmp,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [XLEN-1:0]   cfg_wdata,
   input  logic              acc_valid,
   input  logic [1:0]        acc_kind,
   input  logic [XLEN-1:0]   acc_addr,
   input  logic [XLEN-1:0]   acc_data,
   input  logic [1:0]        acc_priv,
   input  logic              halted,
   input  logic              narrow,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [2:0]        hit_action
);
   if (NUM_TRIG < 2 || NUM_TRIG > 64) begin : g_bad_count
      $error("dbg_trig_match: NUM_TRIG must lie in 2..64");
   end
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("dbg_trig_match: XLEN must be 32 or 64");
   end

   trig_ctl_t [NUM_TRIG-1:0]      ctl_q;
   logic [NUM_TRIG-1:0][XLEN-1:0] cmp_q;
   logic [NUM_TRIG-1:0]           match, chain;
   logic [NUM_TRIG-1:0][2:0]      action;
   logic                          gate;

   assign gate = acc_valid && !halted;

   dtm_trig_bank #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_cmp(cfg_cmp),
      .wr_idx(cfg_idx), .wr_data(cfg_wdata), .ctl_q(ctl_q), .cmp_q(cmp_q)
   );

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
      logic m;
      dtm_cmp #(.XLEN(XLEN)) u_cmp (
         .ctl(ctl_q[g]), .cmp_val(cmp_q[g]), .kind(acc_kind), .priv(acc_priv),
         .addr(acc_addr), .data(acc_data), .narrow(narrow), .match(m)
      );
      assign match[g]  = gate && m;
      assign chain[g]  = ctl_q[g].chain;
      assign action[g] = ctl_q[g].action;
   end

   dtm_resolve #(.NUM_TRIG(NUM_TRIG)) u_res (
      .match(match), .chain(chain), .action(action),
      .hit(hit), .hit_idx(hit_idx), .hit_action(hit_action)
   );
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
   import dtm_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 64,
   localparam int IDX_W   = $clog2(NUM_TRIG)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cfg_we,
   input logic                      cfg_cmp,
   input logic [IDX_W-1:0]          cfg_idx,
   input logic [CTL_W-1:0]          cfg_ctl_word,
   input logic                      acc_valid,
   input logic                      halted,
   input logic                      hit,
   input logic [IDX_W-1:0]          hit_idx,
   input trig_ctl_t [NUM_TRIG-1:0]  ctl_q
);
   assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hit);

   assert_halt_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !hit);

   assert_idle_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !hit);

   assert_chained_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !ctl_q[hit_idx].chain);

   assert_index_in_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (int'(hit_idx) < NUM_TRIG));

   assert_ctl_loaded_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_cmp) |=> (ctl_q[$past(cfg_idx)] == $past(cfg_ctl_word)));
endmodule

bind dbg_trig_match dtm_checker #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cmp(cfg_cmp),
   .cfg_idx(cfg_idx), .cfg_ctl_word(cfg_wdata[dtm_pkg::CTL_W-1:0]),
   .acc_valid(acc_valid), .halted(halted), .hit(hit), .hit_idx(hit_idx),
   .ctl_q(ctl_q)
);

// File: tb/sim_dbg_trig_match.sv
module sim_dbg_trig_match;
   localparam int NT = 4;
   localparam int XW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_cmp = 1'b0;
   logic [1:0]    cfg_idx = '0;
   logic [XW-1:0] cfg_wdata = '0;
   logic          acc_valid = 1'b0;
   logic [1:0]    acc_kind = '0, acc_priv = '0;
   logic [XW-1:0] acc_addr = '0, acc_data = '0;
   logic          halted = 1'b0, narrow = 1'b0;
   logic          hit;
   logic [1:0]    hit_idx;
   logic [2:0]    hit_action;

   always #4 clk = ~clk;

   dbg_trig_match #(.NUM_TRIG(NT), .XLEN(XW)) u0 (.*);

   typedef struct {
      logic       hit;
      logic [1:0] idx;
      logic [2:0] act;
      string      tag;
   } exp_t;

   exp_t q[$];
   event sample_ev;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   // monitor: pops one expected item per sampled access
   initial begin
      forever begin
         @(sample_ev);
         if (q.size() == 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard empty: actual hit=%0b expected an item", hit);
         end else begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (hit !== e.hit || (e.hit && (hit_idx !== e.idx || hit_action !== e.act))) begin
               n_fail++;
               $display("FAIL %s: actual hit=%0b idx=%0d act=%0d expected hit=%0b idx=%0d act=%0d",
                        e.tag, hit, hit_idx, hit_action, e.hit, e.idx, e.act);
            end
         end
      end
   end

   function automatic logic [XW-1:0] ctlw(bit fe, bit ld, bit st, bit u, bit s, bit m,
                                          bit dsel, int mode, bit ch, int act);
      logic [13:0] w;
      w = {act[2:0], ch, mode[2:0], dsel, m, s, u, st, ld, fe};
      return {{(XW-14){1'b0}}, w};
   endfunction

   task automatic wr(input int idx, input bit is_cmp, input logic [XW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_cmp = is_cmp; cfg_idx = idx[1:0]; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic acc(input bit v, input int kind, input logic [XW-1:0] a, input logic [XW-1:0] d,
                      input int priv, input bit h, input bit nar,
                      input bit ehit, input int eidx, input int eact, input string tag);
      exp_t e;
      @(negedge clk);
      acc_valid = v; acc_kind = kind[1:0]; acc_addr = a; acc_data = d;
      acc_priv = priv[1:0]; halted = h; narrow = nar;
      e.hit = ehit; e.idx = eidx[1:0]; e.act = eact[2:0]; e.tag = tag;
      q.push_back(e);
      #2;
      -> sample_ev;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual run still busy expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty bank after reset
      acc(1, 0, 64'h0, 64'h0, 3, 0, 0, 0, 0, 0, "R1 reset fetch");
      acc(1, 2, 64'h0, 64'h0, 0, 0, 0, 0, 0, 0, "R1 reset store");

      // R12/R5: trigger 0 fetch, M, address, equal, action 1
      wr(0, 1, 64'h1000);
      wr(0, 0, ctlw(1,0,0,0,0,1,0,0,0,1));
      acc(1, 0, 64'h1000, 64'h0, 3, 0, 0, 1, 0, 1, "R5 equal hit");
      acc(1, 0, 64'h1004, 64'h0, 3, 0, 0, 0, 0, 0, "R5 equal miss");
      acc(1, 1, 64'h1000, 64'h0, 3, 0, 0, 0, 0, 0, "R2 kind disabled");
      acc(1, 0, 64'h1000, 64'h0, 0, 0, 0, 0, 0, 0, "R2 privilege disabled");
      acc(1, 0, 64'h1000, 64'h0, 2, 0, 0, 0, 0, 0, "R2 reserved privilege");
      acc(1, 0, 64'h1000, 64'h0, 3, 1, 0, 0, 0, 0, "R3 halted");
      acc(0, 0, 64'h1000, 64'h0, 3, 0, 0, 0, 0, 0, "R3 no access");

      // R9: narrow mode drops the upper address bits
      acc(1, 0, 64'hFFFF_FFFF_0000_1000, 64'h0, 3, 0, 1, 1, 0, 1, "R9 narrow hit");
      acc(1, 0, 64'hFFFF_FFFF_0000_1000, 64'h0, 3, 0, 0, 0, 0, 0, "R9 wide miss");

      // R6: range with two trailing ones
      wr(0, 1, 64'h2003);
      wr(0, 0, ctlw(1,0,0,0,0,1,0,1,0,1));
      acc(1, 0, 64'h2002, 64'h0, 3, 0, 0, 1, 0, 1, "R6 range inside");
      acc(1, 0, 64'h2004, 64'h0, 3, 0, 0, 0, 0, 0, "R6 range above");
      acc(1, 0, 64'h1FFF, 64'h0, 3, 0, 0, 0, 0, 0, "R6 range below");

      // R7: unsigned GE / LT at the boundary
      wr(0, 1, 64'h100);
      wr(0, 0, ctlw(1,0,0,0,0,1,0,2,0,1));
      acc(1, 0, 64'h100, 64'h0, 3, 0, 0, 1, 0, 1, "R7 ge equal");
      acc(1, 0, 64'hFF, 64'h0, 3, 0, 0, 0, 0, 0, "R7 ge below");
      acc(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3, 0, 0, 1, 0, 1, "R7 ge unsigned top");
      wr(0, 0, ctlw(1,0,0,0,0,1,0,3,0,1));
      acc(1, 0, 64'hFF, 64'h0, 3, 0, 0, 1, 0, 1, "R7 lt below");
      acc(1, 0, 64'h100, 64'h0, 3, 0, 0, 0, 0, 0, "R7 lt equal");
      wr(0, 0, ctlw(1,0,0,0,0,1,0,6,0,1));
      acc(1, 0, 64'h100, 64'h0, 3, 0, 0, 0, 0, 0, "R7 undefined mode");

      // R8: half masks, mask 0xFF, target 0x34
      wr(0, 1, 64'h0000_00FF_0000_0034);
      wr(0, 0, ctlw(1,0,0,0,0,1,0,4,0,1));
      acc(1, 0, 64'hABCD_1234, 64'h0, 3, 0, 0, 1, 0, 1, "R8 low mask hit");
      acc(1, 0, 64'hABCD_1235, 64'h0, 3, 0, 0, 0, 0, 0, "R8 low mask miss");
      wr(0, 0, ctlw(1,0,0,0,0,1,0,5,0,1));
      acc(1, 0, 64'h0000_0034_0000_0000, 64'h0, 3, 0, 0, 1, 0, 1, "R8 high mask hit");
      acc(1, 0, 64'h34, 64'h0, 3, 0, 0, 0, 0, 0, "R8 high mask miss");

      // R4: store in U, compare on data
      wr(0, 1, 64'hDEAD);
      wr(0, 0, ctlw(0,0,1,1,0,0,1,0,0,4));
      acc(1, 2, 64'hDEAD, 64'h0, 0, 0, 0, 0, 0, 0, "R4 address ignored");
      acc(1, 2, 64'h0, 64'hDEAD, 0, 0, 0, 1, 0, 4, "R4 data compared");
      acc(1, 2, 64'h0, 64'hDEAD, 1, 0, 0, 0, 0, 0, "R2 S not enabled");

      // R10: chain 1->2, standalone 3
      wr(0, 0, 64'h0);
      wr(1, 1, 64'h500);
      wr(1, 0, ctlw(1,0,0,0,0,1,0,0,1,2));
      wr(2, 1, 64'h77);
      wr(2, 0, ctlw(1,0,0,0,0,1,1,0,0,3));
      wr(3, 1, 64'h77);
      wr(3, 0, ctlw(1,0,0,0,0,1,1,0,0,4));
      acc(1, 0, 64'h500, 64'h77, 3, 0, 0, 1, 2, 3, "R10 chain both match");
      acc(1, 0, 64'h500, 64'h78, 3, 0, 0, 0, 0, 0, "R10 chained member alone");
      acc(1, 0, 64'h501, 64'h77, 3, 0, 0, 1, 3, 4, "R10 chain broken, next closes");

      // R11: lowest index wins
      wr(0, 1, 64'h0);
      wr(0, 0, ctlw(1,0,0,0,0,1,0,2,0,0));
      acc(1, 0, 64'h500, 64'h77, 3, 0, 0, 1, 0, 0, "R11 lowest index");
      wr(0, 0, 64'h0);

      // R10: trailing chained trigger never fires
      wr(3, 0, ctlw(1,0,0,0,0,1,1,0,1,4));
      acc(1, 0, 64'h501, 64'h77, 3, 0, 0, 0, 0, 0, "R10 open chain at end");
      acc(1, 0, 64'h500, 64'h77, 3, 0, 0, 1, 2, 3, "R10 earlier chain still fires");

      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule